// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Engine

This block is one DMA channel. It copies data from a source address to a target address. The work is described by a linked list of four-word descriptors held in memory. Software writes the address of the first descriptor into the pointer register and sets the run bit. The channel then reads the descriptor words in turn: next pointer, source, target and command. It moves the byte count of that descriptor one element at a time, and then follows the next pointer. It halts at the first descriptor whose next pointer carries the stop flag.

Each command word selects the element width, whether each address steps after an element, and whether peripheral request lines pace the transfer in bursts. It also enables a start interrupt and an end interrupt for that descriptor. A direct mode skips the descriptor fetch and runs from the source, target and command registers exactly as software wrote them. A memory error ends the channel at once. Software can also halt the channel by clearing run.

Register indices on `reg_addr_i`: 0 control/status, 1 descriptor pointer, 2 source, 3 target, 4 command. Other indices read as zero.

Top module: `dma_chain_top`

## Requirements
- R1: After reset the control/status register reads 0x00000008, with only the stopped bit 3 set. `irq_o` is low and `mem_req_o` is low.
- R2: If run (status bit 31) is set while direct mode (bit 30) is clear, the channel reads four 32-bit words at pointer+0, +4, +8 and +12. These words are the next pointer, the source, the target and the command, in that order. The command register then reads back the fetched command.
- R3: Bits [31:4] of the next word give the next descriptor address, with the low four bits forced to zero. Bit 0 of the next word means stop after this descriptor. When that descriptor finishes, run clears and stopped (bit 3) sets. The pointer register then holds the address of the last descriptor that was fetched.
- R4: The byte count is command bits [12:0]. It drops by the element width after each element. A count of zero moves no data and makes no data access.
- R5: The element width is command bits [15:14]: 1 gives 1 byte, 2 gives 2 bytes and 3 gives 4 bytes. Each element is read from the source and then written to the target. `mem_size_o` carries the size (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). Data sits right-justified in little-endian byte order.
- R6: Command bit 31 steps the source by the element width after each element, and bit 30 does the same for the target. An address whose bit is clear stays fixed. The source and target registers read back the current addresses.
- R7: Command bit 29 paces the transfer on `src_req_i` and bit 28 paces it on `tgt_req_i`; if both are set, both requests are needed. At the start of each burst the channel waits for the request. It then moves one burst without waiting again. The burst length is command bits [17:16]: 1 gives 8 bytes, 2 gives 16 bytes, 3 gives 32 bytes, and 0 gives one element. With both pace bits clear the transfer runs without waiting.
- R8: Status bit 1 (start) sets when a descriptor whose command bit 22 is set is loaded. Status bit 2 (end) sets when a descriptor whose command bit 21 is set completes. `irq_o` is the OR of status bits 2..0.
- R9: Writing 1 to a status bit 2..0 clears it. Writing 0 to it leaves it unchanged.
- R10: An error on an acknowledged memory access aborts the transfer at once. It sets status bit 0, clears run and sets stopped. The failed write, and any later access, is not carried out.
- R11: Clearing run during a transfer halts the channel before the next element starts, and stopped then reads 1.
- R12: Writes to the pointer, source, target and command registers take effect only while stopped. At other times they are ignored.
- R13: In direct mode no descriptor is fetched. The source, target and command registers drive the transfer, and the channel always stops when the count is exhausted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the addressed index |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address |
| mem_size_o | output | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| mem_wdata_o | output | 32 | Write data, right-justified |
| mem_ack_i | input | 1 | Access completed |
| mem_err_i | input | 1 | Access failed, valid with ack |
| mem_rdata_i | input | 32 | Read data, right-justified, valid with ack |
| src_req_i | input | 1 | Source peripheral request |
| tgt_req_i | input | 1 | Target peripheral request |
| irq_o | output | 1 | Interrupt, the OR of the pending status bits |

## Verification
A wrong fetch index or a stale pointer shows at the ports as a write to the wrong target, or as wrong data. The scoreboard sees it on the first bad element write, a few cycles after the descriptor fetch. A count or burst register that fails to step shows as a missing or extra element write. For a paced burst, the bench counts the writes made after one request, so this shows within a single burst. Faults in the status and run logic appear in the control/status readback and on `irq_o` as soon as the channel reports stopped.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int DW = 32;
  localparam int BW = 6;

  // command word fields
  localparam int CMD_INC_SRC   = 31;
  localparam int CMD_INC_TGT   = 30;
  localparam int CMD_PACE_SRC  = 29;
  localparam int CMD_PACE_TGT  = 28;
  localparam int CMD_START_IE  = 22;
  localparam int CMD_END_IE    = 21;
  localparam int CMD_BURST_LSB = 16;
  localparam int CMD_WIDTH_LSB = 14;

  // control/status fields
  localparam int CSR_RUN     = 31;
  localparam int CSR_DIRECT  = 30;
  localparam int CSR_STOPPED = 3;
  localparam int CSR_END     = 2;
  localparam int CSR_START   = 1;
  localparam int CSR_ERR     = 0;

  localparam int NEXT_STOP  = 0;
  localparam int NEXT_ALIGN = 4;

  localparam int REG_CSR = 0;
  localparam int REG_PTR = 1;
  localparam int REG_SRC = 2;
  localparam int REG_TGT = 3;
  localparam int REG_CMD = 4;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_RD, S_WR} chan_state_e;
endpackage

// File: rtl/dma_chain_cmd_dec.sv
module dma_chain_cmd_dec
  import dma_chain_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic [DW-1:0]    cmd_i,
  output logic [LEN_W-1:0] len_o,
  output logic [BW-1:0]    elem_bytes_o,
  output logic [BW-1:0]    burst_bytes_o,
  output logic [1:0]       size_o,
  output logic [DW-1:0]    elem_mask_o,
  output logic             inc_src_o,
  output logic             inc_tgt_o,
  output logic             pace_src_o,
  output logic             pace_tgt_o,
  output logic             start_ie_o,
  output logic             end_ie_o
);
  assign len_o      = cmd_i[LEN_W-1:0];
  assign inc_src_o  = cmd_i[CMD_INC_SRC];
  assign inc_tgt_o  = cmd_i[CMD_INC_TGT];
  assign pace_src_o = cmd_i[CMD_PACE_SRC];
  assign pace_tgt_o = cmd_i[CMD_PACE_TGT];
  assign start_ie_o = cmd_i[CMD_START_IE];
  assign end_ie_o   = cmd_i[CMD_END_IE];

  always_comb begin
    unique case (cmd_i[CMD_WIDTH_LSB +: 2])
      2'd1:    begin size_o = 2'd0; elem_bytes_o = BW'(1); elem_mask_o = DW'(32'h0000_00FF); end
      2'd2:    begin size_o = 2'd1; elem_bytes_o = BW'(2); elem_mask_o = DW'(32'h0000_FFFF); end
      default: begin size_o = 2'd2; elem_bytes_o = BW'(4); elem_mask_o = '1; end
    endcase
    unique case (cmd_i[CMD_BURST_LSB +: 2])
      2'd1:    burst_bytes_o = BW'(8);
      2'd2:    burst_bytes_o = BW'(16);
      2'd3:    burst_bytes_o = BW'(32);
      default: burst_bytes_o = elem_bytes_o;
    endcase
  end
endmodule

// File: rtl/dma_chain_csr.sv
module dma_chain_csr
  import dma_chain_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          set_start_i,
  input  logic          set_end_i,
  input  logic          set_err_i,
  input  logic          halt_i,
  output logic          run_o,
  output logic          direct_o,
  output logic          start_o,
  output logic          end_o,
  output logic          err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o    <= 1'b0;
      direct_o <= 1'b0;
      start_o  <= 1'b0;
      end_o    <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      if (wr_i) begin
        run_o    <= wdata_i[CSR_RUN];
        direct_o <= wdata_i[CSR_DIRECT];
      end
      if (halt_i) run_o <= 1'b0;
      // set events win over a same-cycle clear
      start_o <= set_start_i | (start_o & ~(wr_i & wdata_i[CSR_START]));
      end_o   <= set_end_i   | (end_o   & ~(wr_i & wdata_i[CSR_END]));
      err_o   <= set_err_i   | (err_o   & ~(wr_i & wdata_i[CSR_ERR]));
    end
  end

  a_r9_w1c_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[CSR_END] && !set_end_i) |=> !end_o);
  a_r9_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !(wr_i && wdata_i[CSR_START])) |=> start_o);
  a_r10_err_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_err_i |=> err_o);
  a_r3_halt_clears_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> !run_o);
endmodule

// File: rtl/dma_chain_top.sv
module dma_chain_top
  import dma_chain_pkg::*;
#(
  parameter int LEN_W  = 13,
  parameter int REG_AW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic              src_req_i,
  input  logic              tgt_req_i,
  output logic              irq_o
);
  chan_state_e      state_q;
  logic [DW-1:0]    ptr_q, next_q, src_q, tgt_q, cmd_q, data_q;
  logic [LEN_W-1:0] remain_q;
  logic [BW-1:0]    burst_q;
  logic [1:0]       fidx_q;

  logic [LEN_W-1:0] len;
  logic [BW-1:0]    elem_bytes, burst_bytes;
  logic [1:0]       size;
  logic [DW-1:0]    elem_mask;
  logic inc_src, inc_tgt, pace_src, pace_tgt, start_ie, end_ie;
  logic run, direct, st_start, st_end, st_err;

  dma_chain_cmd_dec #(.LEN_W(LEN_W)) u_dec (
    .cmd_i(cmd_q), .len_o(len), .elem_bytes_o(elem_bytes), .burst_bytes_o(burst_bytes),
    .size_o(size), .elem_mask_o(elem_mask), .inc_src_o(inc_src), .inc_tgt_o(inc_tgt),
    .pace_src_o(pace_src), .pace_tgt_o(pace_tgt), .start_ie_o(start_ie), .end_ie_o(end_ie)
  );

  logic stopped, cfg_wr, csr_wr, paced, ok_go, fetch_last, desc_done, chain_stop;
  logic ev_start, ev_end, ev_err, halt;

  assign stopped    = (state_q == S_IDLE);
  assign cfg_wr     = reg_we_i && stopped;
  assign csr_wr     = reg_we_i && (reg_addr_i == REG_AW'(REG_CSR));
  assign paced      = pace_src || pace_tgt;
  assign ok_go      = (!pace_src || src_req_i) && (!pace_tgt || tgt_req_i);
  assign fetch_last = (state_q == S_FETCH) && mem_ack_i && !mem_err_i && (fidx_q == 2'd3);
  assign desc_done  = (state_q == S_CHECK) && run && (remain_q == '0);
  assign chain_stop = direct || next_q[NEXT_STOP];
  assign ev_start   = (fetch_last && mem_rdata_i[CMD_START_IE]) ||
                      (stopped && run && direct && start_ie);
  assign ev_end     = desc_done && end_ie;
  assign ev_err     = mem_req_o && mem_ack_i && mem_err_i;
  assign halt       = ev_err || (desc_done && chain_stop);

  dma_chain_csr u_csr (
    .clk_i, .rst_ni, .wr_i(csr_wr), .wdata_i(reg_wdata_i),
    .set_start_i(ev_start), .set_end_i(ev_end), .set_err_i(ev_err), .halt_i(halt),
    .run_o(run), .direct_o(direct), .start_o(st_start), .end_o(st_end), .err_o(st_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      ptr_q    <= '0;
      next_q   <= '0;
      src_q    <= '0;
      tgt_q    <= '0;
      cmd_q    <= '0;
      data_q   <= '0;
      remain_q <= '0;
      burst_q  <= '0;
      fidx_q   <= '0;
    end else begin
      if (cfg_wr) begin
        if (reg_addr_i == REG_AW'(REG_PTR)) ptr_q <= reg_wdata_i;
        if (reg_addr_i == REG_AW'(REG_SRC)) src_q <= reg_wdata_i;
        if (reg_addr_i == REG_AW'(REG_TGT)) tgt_q <= reg_wdata_i;
        if (reg_addr_i == REG_AW'(REG_CMD)) cmd_q <= reg_wdata_i;
      end
      unique case (state_q)
        S_IDLE: if (run) begin
          fidx_q  <= '0;
          burst_q <= '0;
          if (direct) begin
            remain_q <= len;
            state_q  <= S_CHECK;
          end else begin
            state_q  <= S_FETCH;
          end
        end
        S_FETCH: if (mem_ack_i) begin
          if (mem_err_i) state_q <= S_IDLE;
          else begin
            unique case (fidx_q)
              2'd0: next_q <= mem_rdata_i;
              2'd1: src_q  <= mem_rdata_i;
              2'd2: tgt_q  <= mem_rdata_i;
              default: begin
                cmd_q    <= mem_rdata_i;
                remain_q <= mem_rdata_i[LEN_W-1:0];
                burst_q  <= '0;
                state_q  <= S_CHECK;
              end
            endcase
            fidx_q <= fidx_q + 2'd1;
          end
        end
        S_CHECK: begin
          if (!run) state_q <= S_IDLE;
          else if (remain_q == '0) begin
            if (chain_stop) state_q <= S_IDLE;
            else begin
              ptr_q   <= {next_q[DW-1:NEXT_ALIGN], {NEXT_ALIGN{1'b0}}};
              fidx_q  <= '0;
              state_q <= S_FETCH;
            end
          end else if (paced && burst_q == '0) begin
            if (ok_go) begin
              burst_q <= burst_bytes;
              state_q <= S_RD;
            end
          end else begin
            state_q <= S_RD;
          end
        end
        S_RD: if (mem_ack_i) begin
          if (mem_err_i) state_q <= S_IDLE;
          else begin
            data_q  <= mem_rdata_i & elem_mask;
            state_q <= S_WR;
          end
        end
        S_WR: if (mem_ack_i) begin
          if (mem_err_i) state_q <= S_IDLE;
          else begin
            if (inc_src) src_q <= src_q + DW'(elem_bytes);
            if (inc_tgt) tgt_q <= tgt_q + DW'(elem_bytes);
            remain_q <= (remain_q > LEN_W'(elem_bytes)) ? remain_q - LEN_W'(elem_bytes) : '0;
            burst_q  <= (burst_q > elem_bytes) ? burst_q - elem_bytes : '0;
            state_q  <= S_CHECK;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = (state_q == S_FETCH) || (state_q == S_RD) || (state_q == S_WR);
    mem_we_o    = (state_q == S_WR);
    mem_wdata_o = data_q;
    unique case (state_q)
      S_FETCH: begin mem_addr_o = ptr_q + DW'({fidx_q, 2'b00}); mem_size_o = 2'd2; end
      S_RD:    begin mem_addr_o = src_q; mem_size_o = size; end
      S_WR:    begin mem_addr_o = tgt_q; mem_size_o = size; end
      default: begin mem_addr_o = '0;    mem_size_o = 2'd0; end
    endcase
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_AW'(REG_CSR): begin
        reg_rdata_o[CSR_RUN]     = run;
        reg_rdata_o[CSR_DIRECT]  = direct;
        reg_rdata_o[CSR_STOPPED] = stopped;
        reg_rdata_o[CSR_END]     = st_end;
        reg_rdata_o[CSR_START]   = st_start;
        reg_rdata_o[CSR_ERR]     = st_err;
      end
      REG_AW'(REG_PTR): reg_rdata_o = ptr_q;
      REG_AW'(REG_SRC): reg_rdata_o = src_q;
      REG_AW'(REG_TGT): reg_rdata_o = tgt_q;
      REG_AW'(REG_CMD): reg_rdata_o = cmd_q;
      default:          reg_rdata_o = '0;
    endcase
  end

  assign irq_o = st_end | st_start | st_err;

  a_r10_err_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && mem_err_i) |=> (!mem_req_o && stopped));
  a_r7_pace_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CHECK && run && remain_q != '0 && paced && burst_q == '0 && !ok_go)
      |=> !mem_req_o);
  a_r11_soft_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CHECK && !run) |=> (stopped && !mem_req_o));
  a_r12_cmd_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_AW'(REG_CMD) && state_q != S_IDLE && state_q != S_FETCH)
      |=> $stable(cmd_q));
  a_r4_count_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WR && mem_ack_i && !mem_err_i) |=> (remain_q < $past(remain_q)));
endmodule

// File: tb/dma_chain_top_tb_top.sv
`timescale 1ns/1ps
module dma_chain_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        src_req = 1'b0, tgt_req = 1'b0;
  logic        irq;

  always #2 clk = ~clk;

  dma_chain_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_size_o(mem_size), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_err_i(mem_err), .mem_rdata_i(mem_rdata), .src_req_i(src_req), .tgt_req_i(tgt_req),
    .irq_o(irq)
  );

  typedef struct packed {logic [31:0] addr; logic [1:0] size; logic [31:0] data;} wr_item_t;
  wr_item_t exp_q[$];
  string    tag_q[$];
  logic [7:0] mem [0:4095];
  int n_chk = 0, n_bad = 0, n_wr = 0, n_rd = 0;

  task automatic check_eq(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] get_elem(logic [31:0] a, int n);
    logic [31:0] r = '0;
    for (int k = 0; k < n; k++) r[8*k +: 8] = mem[12'(a + k)];
    return r;
  endfunction

  task automatic put_word(logic [31:0] a, logic [31:0] w);
    for (int k = 0; k < 4; k++) mem[12'(a + k)] = w[8*k +: 8];
  endtask

  // driver: expected element writes into the scoreboard
  task automatic push_copy(string tag, logic [31:0] s, logic [31:0] t, int len, int w,
                           bit inc_s, bit inc_t);
    wr_item_t it;
    for (int i = 0; i < len / w; i++) begin
      it.addr = t;
      it.size = (w == 1) ? 2'd0 : (w == 2) ? 2'd1 : 2'd2;
      it.data = get_elem(s, w);
      exp_q.push_back(it);
      tag_q.push_back(tag);
      if (inc_s) s = s + w;
      if (inc_t) t = t + w;
    end
  endtask

  // memory model and monitor
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req) begin
      int n;
      n = 1 << mem_size;
      if (mem_addr[31:12] != '0) mem_err = 1'b1;
      else if (mem_we) begin
        wr_item_t e;
        string t;
        n_wr++;
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R5 unexpected write: actual %h expected none", mem_addr);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check_eq(t, "write addr", mem_addr, e.addr);
          check_eq(t, "write size", 32'(mem_size), 32'(e.size));
          check_eq(t, "write data", mem_wdata, e.data);
        end
        for (int k = 0; k < n; k++) mem[12'(mem_addr + k)] = mem_wdata[8*k +: 8];
      end else begin
        n_rd++;
        mem_rdata = get_elem(mem_addr, n);
      end
      mem_ack = 1'b1;
    end
  end

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_stop();
    logic [31:0] v;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 5000; i++) begin
      reg_rd(3'd0, v);
      if (v[3]) break;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int w0, r0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_rd(3'd0, v); check_eq("R1", "csr after reset", v, 32'h8);
    check_eq("R1", "irq after reset", 32'(irq), 0);
    check_eq("R1", "mem_req after reset", 32'(mem_req), 0);

    // R2 R3 R5 R6 R8: two-descriptor chain
    put_word(32'h100, 32'h120);  put_word(32'h104, 32'h400);
    put_word(32'h108, 32'h600);  put_word(32'h10C, 32'hC040_C008);
    put_word(32'h120, 32'h1);    put_word(32'h124, 32'h500);
    put_word(32'h128, 32'h700);  put_word(32'h12C, 32'hC020_8006);
    push_copy("R2", 32'h400, 32'h600, 8, 4, 1, 1);
    push_copy("R5", 32'h500, 32'h700, 6, 2, 1, 1);
    reg_wr(3'd1, 32'h100);
    reg_wr(3'd0, 32'h8000_0000);
    wait_stop();
    reg_rd(3'd0, v); check_eq("R3", "csr after chain (start+end+stopped)", v, 32'hE);
    check_eq("R8", "irq with status pending", 32'(irq), 1);
    reg_rd(3'd1, v); check_eq("R3", "pointer holds last descriptor", v, 32'h120);
    reg_rd(3'd4, v); check_eq("R2", "command from fetch", v, 32'hC020_8006);
    reg_rd(3'd2, v); check_eq("R6", "source advanced", v, 32'h506);
    reg_rd(3'd3, v); check_eq("R6", "target advanced", v, 32'h706);
    check_eq("R2", "scoreboard drained", 32'(exp_q.size()), 0);

    // R9 write-one-to-clear
    reg_wr(3'd0, 32'h4);
    reg_rd(3'd0, v); check_eq("R9", "clear end only", v, 32'hA);
    reg_wr(3'd0, 32'h2);
    reg_rd(3'd0, v); check_eq("R9", "clear start", v, 32'h8);
    check_eq("R8", "irq after clear", 32'(irq), 0);

    // R7 R13: direct mode, byte elements, fixed target, paced on target, 8-byte bursts
    reg_wr(3'd2, 32'h800);
    reg_wr(3'd3, 32'h900);
    reg_wr(3'd4, 32'h9001_400A);
    push_copy("R7", 32'h800, 32'h900, 10, 1, 1, 0);
    w0 = n_wr; r0 = n_rd;
    reg_wr(3'd0, 32'hC000_0000);
    repeat (20) @(negedge clk);
    check_eq("R7", "no write without request", 32'(n_wr - w0), 0);
    reg_rd(3'd2, v); check_eq("R7", "source held while waiting", v, 32'h800);
    tgt_req = 1'b1;
    for (int i = 0; i < 200 && n_wr == w0; i++) @(negedge clk);
    tgt_req = 1'b0;
    repeat (80) @(negedge clk);
    check_eq("R7", "one burst of 8 bytes", 32'(n_wr - w0), 8);
    reg_rd(3'd2, v); check_eq("R6", "source after burst", v, 32'h808);
    reg_rd(3'd0, v); check_eq("R7", "still running between bursts", v, 32'hC000_0000);
    tgt_req = 1'b1;
    wait_stop();
    tgt_req = 1'b0;
    check_eq("R7", "all elements moved", 32'(n_wr - w0), 10);
    check_eq("R13", "reads only for data", 32'(n_rd - r0), 10);
    reg_rd(3'd0, v); check_eq("R13", "direct mode stops, no end irq", v, 32'h4000_0008);
    reg_rd(3'd3, v); check_eq("R6", "fixed target", v, 32'h900);

    // R4 zero length in direct mode
    reg_wr(3'd4, 32'h0020_0000);
    w0 = n_wr; r0 = n_rd;
    reg_wr(3'd0, 32'hC000_0000);
    wait_stop();
    reg_rd(3'd0, v); check_eq("R4", "zero length completes with end", v, 32'h4000_000C);
    check_eq("R4", "zero length no access", 32'((n_wr - w0) + (n_rd - r0)), 0);
    reg_wr(3'd0, 32'h4);

    // R11 R12: locked registers while running, then software stop
    reg_wr(3'd2, 32'h800);
    reg_wr(3'd3, 32'hA00);
    reg_wr(3'd4, 32'hE000_C010);
    w0 = n_wr;
    reg_wr(3'd0, 32'hC000_0000);
    repeat (10) @(negedge clk);
    reg_wr(3'd1, 32'h1E0);
    reg_rd(3'd1, v); check_eq("R12", "pointer write ignored while running", v, 32'h120);
    reg_wr(3'd4, 32'h123);
    reg_rd(3'd4, v); check_eq("R12", "command write ignored while running", v, 32'hE000_C010);
    reg_wr(3'd0, 32'h4000_0000);
    repeat (5) @(negedge clk);
    reg_rd(3'd0, v); check_eq("R11", "stopped after run cleared", v, 32'h4000_0008);
    check_eq("R11", "no element moved", 32'(n_wr - w0), 0);
    reg_wr(3'd1, 32'h1E0);
    reg_rd(3'd1, v); check_eq("R12", "pointer write while stopped", v, 32'h1E0);

    // R10 bus error on source read
    put_word(32'h140, 32'h1);       put_word(32'h144, 32'h0001_0000);
    put_word(32'h148, 32'hB00);     put_word(32'h14C, 32'hC000_C008);
    w0 = n_wr;
    reg_wr(3'd1, 32'h140);
    reg_wr(3'd0, 32'h8000_0000);
    wait_stop();
    reg_rd(3'd0, v); check_eq("R10", "error flag, run clear", v, 32'h9);
    check_eq("R10", "irq on error", 32'(irq), 1);
    check_eq("R10", "no write after error", 32'(n_wr - w0), 0);
    reg_wr(3'd0, 32'h1);
    reg_rd(3'd0, v); check_eq("R9", "error cleared", v, 32'h8);

    check_eq("R5", "scoreboard empty at end", 32'(exp_q.size()), 0);
    summary();
    $finish;
  end
endmodule